// File: doc/BRIEF.md
# Four-Stage Pipelined Floating-Point Adder

This block adds or subtracts two normalized binary floating-point numbers in a 16-bit format. It takes one operand pair per clock and returns one normalized result per clock. Each result appears four clocks after its operands were sampled. The work is split into four registered stages:

- **Compare:** orders the operands by magnitude and keeps the larger exponent.
- **Align:** shifts the smaller mantissa right by the exponent gap.
- **Add:** adds or subtracts the two mantissas.
- **Normalize:** restores the leading one and corrects the exponent.

A valid flag travels with every operand pair. It marks which output cycles carry a real result.

Precision is limited to truncation. Any bit shifted out of the smaller mantissa, or dropped when a carry is folded back, is lost. Infinities, NaNs and denormals are not modelled. Exponent overflow is avoided by keeping input exponents at 61 or below. A result that would need an exponent below 1 is flushed to zero.

Top module: `fpa_pipe4`

## Requirements
- R1: A pair sampled at clock edge N, with `in_valid` high, yields `out_valid` high and its result right after edge N+3. `in_valid` low yields `out_valid` low at the same distance. A new pair is accepted on every clock.
- R2: The word layout is sign at bit 15, a 6-bit exponent with bias 31 at bits 14:9, and a 9-bit fraction at bits 8:0. The fraction has an implied leading one. An operand whose exponent field is 0 counts as zero, so 0 + x returns x unchanged.
- R3: `op_sub` = 1 computes a − b by inverting the sign of b before anything else. `op_sub` = 0 computes a + b.
- R4: The operand of smaller magnitude has its 10-bit mantissa (implied one included) shifted right by the exponent difference. Shifted-out bits are discarded. The result starts from the larger exponent.
- R5: When the exponent difference exceeds 10, the smaller operand contributes nothing, so the result equals the larger operand (with its effective sign).
- R6: When the mantissa addition carries out, the 11-bit sum is shifted right by one, dropping its lowest bit, and the exponent rises by one.
- R7: When subtraction clears leading bits, the sum is shifted left until bit 9 is one. The exponent falls by the shift count.
- R8: A mantissa result of zero gives the all-zero word 0x0000. So does a left shift that would push the exponent below 1.
- R9: The result sign is the effective sign of the operand with the larger magnitude, where magnitude is the exponent and fraction compared together.
- R10: While `rst_n` is low at a clock edge, `out_valid` and `out_result` become 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Marks `op_a`/`op_b`/`op_sub` as a real operation this cycle |
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand |
| op_sub | input | 1 | 1 selects a − b, 0 selects a + b |
| out_valid | output | 1 | Marks `out_result` as a real result |
| out_result | output | 16 | Normalized sum or difference |

## Verification
Every result is due exactly four rising edges after its operands were sampled. The bench drives a pair on a falling edge and records the value it predicts in a four-deep ring. On each later falling edge it compares the outputs with the ring entry written four steps earlier, which is the first falling edge after the fourth register has loaded.

The valid flag is compared on every step, including the bubbles. The result word is compared only when a valid result is due. The first four steps after reset must show `out_valid` low, because no pair has yet reached the output.

// File: rtl/fpa_pkg.sv
// Package: shared format constants and helpers for the pipelined adder.
// Assumes: fields are laid out sign | exponent | fraction, MSB first.
package fpa_pkg;
    localparam int FPA_EXP_W  = 6;
    localparam int FPA_FRAC_W = 9;
    localparam int FPA_BIAS   = 31;

    // Count zeros above the highest one in the low w bits of v; returns w if none.
    function automatic int unsigned lead_zeros(logic [31:0] v, int unsigned w);
        int unsigned n;
        logic        found;
        n     = 0;
        found = 1'b0;
        for (int i = 31; i >= 0; i--) begin
            if (i < int'(w) && !found) begin
                if (v[i]) found = 1'b1;
                else      n = n + 1;
            end
        end
        return n;
    endfunction
endpackage

// File: rtl/fpa_compare.sv
// Stage 1: orders the operands by magnitude, applies the subtract select to
// the second sign, expands the hidden one and registers the exponent gap.
// Assumes: exponent field 0 denotes a zero operand.
module fpa_compare #(
    parameter int EXP_W  = 6,
    parameter int FRAC_W = 9,
    localparam int W      = 1 + EXP_W + FRAC_W,
    localparam int MANT_W = FRAC_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [W-1:0]      a_i,
    input  logic [W-1:0]      b_i,
    input  logic              sub_i,
    output logic              valid_o,
    output logic              sign_o,
    output logic [EXP_W-1:0]  exp_o,
    output logic [MANT_W-1:0] big_mant_o,
    output logic [MANT_W-1:0] small_mant_o,
    output logic [EXP_W-1:0]  diff_o,
    output logic              eff_sub_o
);
    logic              b_sign;
    logic              a_is_big;
    logic [EXP_W-1:0]  a_exp, b_exp;
    logic [MANT_W-1:0] a_mant, b_mant;

    // Split the fields and decide which operand has the larger magnitude.
    always_comb begin
        b_sign   = b_i[W-1] ^ sub_i;
        a_exp    = a_i[W-2:FRAC_W];
        b_exp    = b_i[W-2:FRAC_W];
        a_mant   = {(a_exp != '0), a_i[FRAC_W-1:0]};
        b_mant   = {(b_exp != '0), b_i[FRAC_W-1:0]};
        a_is_big = (a_i[W-2:0] >= b_i[W-2:0]);
    end

    // Register the ordered operands, the gap and the effective operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o      <= 1'b0;
            sign_o       <= 1'b0;
            exp_o        <= '0;
            big_mant_o   <= '0;
            small_mant_o <= '0;
            diff_o       <= '0;
            eff_sub_o    <= 1'b0;
        end else begin
            valid_o      <= valid_i;
            sign_o       <= a_is_big ? a_i[W-1] : b_sign;
            exp_o        <= a_is_big ? a_exp : b_exp;
            big_mant_o   <= a_is_big ? a_mant : b_mant;
            small_mant_o <= a_is_big ? b_mant : a_mant;
            diff_o       <= a_is_big ? (a_exp - b_exp) : (b_exp - a_exp);
            eff_sub_o    <= a_i[W-1] ^ b_sign;
        end
    end

    // The valid flag advances exactly one stage per clock.
    assert_valid_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (valid_o == $past(valid_i)));

    // The operand kept as "big" never has the smaller magnitude.
    assert_big_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (big_mant_o >= small_mant_o || diff_o != '0));
endmodule

// File: rtl/fpa_align.sv
// Stage 2: shifts the smaller mantissa right by the exponent gap,
// dropping shifted-out bits; a gap wider than the mantissa yields zero.
// Assumes: stage 1 already placed the larger operand in the big slot.
module fpa_align #(
    parameter int EXP_W  = 6,
    parameter int FRAC_W = 9,
    localparam int MANT_W = FRAC_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic              sign_i,
    input  logic [EXP_W-1:0]  exp_i,
    input  logic [MANT_W-1:0] big_mant_i,
    input  logic [MANT_W-1:0] small_mant_i,
    input  logic [EXP_W-1:0]  diff_i,
    input  logic              eff_sub_i,
    output logic              valid_o,
    output logic              sign_o,
    output logic [EXP_W-1:0]  exp_o,
    output logic [MANT_W-1:0] big_mant_o,
    output logic [MANT_W-1:0] aligned_o,
    output logic              eff_sub_o
);
    logic [MANT_W-1:0] shifted;

    // Right shift with an explicit clamp for gaps beyond the mantissa width.
    always_comb begin
        if (32'(diff_i) > MANT_W) shifted = '0;
        else                      shifted = small_mant_i >> diff_i;
    end

    // Register the aligned pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o    <= 1'b0;
            sign_o     <= 1'b0;
            exp_o      <= '0;
            big_mant_o <= '0;
            aligned_o  <= '0;
            eff_sub_o  <= 1'b0;
        end else begin
            valid_o    <= valid_i;
            sign_o     <= sign_i;
            exp_o      <= exp_i;
            big_mant_o <= big_mant_i;
            aligned_o  <= shifted;
            eff_sub_o  <= eff_sub_i;
        end
    end

    // A gap wider than the mantissa leaves nothing of the smaller operand.
    assert_far_gap_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && 32'(diff_i) > MANT_W) |=> (aligned_o == '0));

    // Alignment never grows the smaller mantissa.
    assert_align_shrinks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> (aligned_o <= $past(small_mant_i)));
endmodule

// File: rtl/fpa_addsub.sv
// Stage 3: adds or subtracts the aligned mantissas into a sum one bit wider.
// Assumes: big mantissa >= aligned mantissa, so subtraction never goes negative.
module fpa_addsub #(
    parameter int EXP_W  = 6,
    parameter int FRAC_W = 9,
    localparam int MANT_W = FRAC_W + 1,
    localparam int SUM_W  = MANT_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic              sign_i,
    input  logic [EXP_W-1:0]  exp_i,
    input  logic [MANT_W-1:0] big_mant_i,
    input  logic [MANT_W-1:0] aligned_i,
    input  logic              eff_sub_i,
    output logic              valid_o,
    output logic              sign_o,
    output logic [EXP_W-1:0]  exp_o,
    output logic [SUM_W-1:0]  sum_o
);
    logic [SUM_W-1:0] sum;

    // Select add or subtract on the widened mantissas.
    always_comb begin
        if (eff_sub_i) sum = {1'b0, big_mant_i} - {1'b0, aligned_i};
        else           sum = {1'b0, big_mant_i} + {1'b0, aligned_i};
    end

    // Register the raw sum.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            sign_o  <= 1'b0;
            exp_o   <= '0;
            sum_o   <= '0;
        end else begin
            valid_o <= valid_i;
            sign_o  <= sign_i;
            exp_o   <= exp_i;
            sum_o   <= sum;
        end
    end

    // A subtraction can never produce a carry-out.
    assert_sub_no_carry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && eff_sub_i) |=> !sum_o[SUM_W-1]);
endmodule

// File: rtl/fpa_normalize.sv
// Stage 4: restores the leading one. A carry shifts right and bumps the
// exponent; cancellation shifts left and lowers it; zero or underflow
// gives the all-zero word.
// Assumes: exponent input stays below its maximum so a carry cannot wrap.
module fpa_normalize #(
    parameter int EXP_W  = 6,
    parameter int FRAC_W = 9,
    localparam int W      = 1 + EXP_W + FRAC_W,
    localparam int MANT_W = FRAC_W + 1,
    localparam int SUM_W  = MANT_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid_i,
    input  logic             sign_i,
    input  logic [EXP_W-1:0] exp_i,
    input  logic [SUM_W-1:0] sum_i,
    output logic             valid_o,
    output logic [W-1:0]     result_o
);
    import fpa_pkg::*;

    int unsigned       lz;
    logic [MANT_W-1:0] mant;
    logic [EXP_W-1:0]  exp_n;
    logic [W-1:0]      packed_res;

    // Pick the normalization case and build the result word.
    always_comb begin
        lz    = lead_zeros(32'(sum_i[MANT_W-1:0]), MANT_W);
        mant  = sum_i[MANT_W-1:0];
        exp_n = exp_i;
        packed_res = '0;
        if (sum_i == '0) begin
            packed_res = '0;
        end else if (sum_i[SUM_W-1]) begin
            mant       = sum_i[SUM_W-1:1];
            exp_n      = exp_i + 1'b1;
            packed_res = {sign_i, exp_n, mant[FRAC_W-1:0]};
        end else if (lz >= 32'(exp_i)) begin
            packed_res = '0;
        end else begin
            mant       = sum_i[MANT_W-1:0] << lz;
            exp_n      = exp_i - EXP_W'(lz);
            packed_res = {sign_i, exp_n, mant[FRAC_W-1:0]};
        end
    end

    // Register the final result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o  <= 1'b0;
            result_o <= '0;
        end else begin
            valid_o  <= valid_i;
            result_o <= packed_res;
        end
    end

    // A carry-out raises the exponent by exactly one.
    assert_carry_bump_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && sum_i[SUM_W-1]) |=>
        (result_o[W-2:FRAC_W] == EXP_W'($past(exp_i) + 1'b1)));

    // A zero exponent in the output always comes with an all-zero word.
    assert_zero_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (result_o[W-2:FRAC_W] == '0) |-> (result_o == '0));
endmodule

// File: rtl/fpa_pipe4.sv
// Top: four-stage floating-point add/subtract pipeline, one pair per clock,
// four clocks of latency. Assumes normalized inputs with exponent <= max-2.
module fpa_pipe4 #(
    parameter int EXP_W  = fpa_pkg::FPA_EXP_W,
    parameter int FRAC_W = fpa_pkg::FPA_FRAC_W,
    localparam int W      = 1 + EXP_W + FRAC_W,
    localparam int MANT_W = FRAC_W + 1,
    localparam int SUM_W  = MANT_W + 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic         op_sub,
    output logic         out_valid,
    output logic [W-1:0] out_result
);
    logic              s1_valid, s1_sign, s1_sub;
    logic [EXP_W-1:0]  s1_exp, s1_diff;
    logic [MANT_W-1:0] s1_big, s1_small;
    logic              s2_valid, s2_sign, s2_sub;
    logic [EXP_W-1:0]  s2_exp;
    logic [MANT_W-1:0] s2_big, s2_aligned;
    logic              s3_valid, s3_sign;
    logic [EXP_W-1:0]  s3_exp;
    logic [SUM_W-1:0]  s3_sum;

    fpa_compare #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_compare (
        .clk(clk), .rst_n(rst_n), .valid_i(in_valid),
        .a_i(op_a), .b_i(op_b), .sub_i(op_sub),
        .valid_o(s1_valid), .sign_o(s1_sign), .exp_o(s1_exp),
        .big_mant_o(s1_big), .small_mant_o(s1_small),
        .diff_o(s1_diff), .eff_sub_o(s1_sub)
    );

    fpa_align #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_align (
        .clk(clk), .rst_n(rst_n), .valid_i(s1_valid),
        .sign_i(s1_sign), .exp_i(s1_exp), .big_mant_i(s1_big),
        .small_mant_i(s1_small), .diff_i(s1_diff), .eff_sub_i(s1_sub),
        .valid_o(s2_valid), .sign_o(s2_sign), .exp_o(s2_exp),
        .big_mant_o(s2_big), .aligned_o(s2_aligned), .eff_sub_o(s2_sub)
    );

    fpa_addsub #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_addsub (
        .clk(clk), .rst_n(rst_n), .valid_i(s2_valid),
        .sign_i(s2_sign), .exp_i(s2_exp), .big_mant_i(s2_big),
        .aligned_i(s2_aligned), .eff_sub_i(s2_sub),
        .valid_o(s3_valid), .sign_o(s3_sign), .exp_o(s3_exp), .sum_o(s3_sum)
    );

    fpa_normalize #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_normalize (
        .clk(clk), .rst_n(rst_n), .valid_i(s3_valid),
        .sign_i(s3_sign), .exp_i(s3_exp), .sum_i(s3_sum),
        .valid_o(out_valid), .result_o(out_result)
    );
endmodule

// File: tb/test_fpa_pipe4.sv
// Bench: directed corner cases plus seeded random pairs, each checked
// against a bench model four clock steps after it was driven.
module test_fpa_pipe4;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] op_a = '0, op_b = '0;
    logic        op_sub = 1'b0;
    logic        out_valid;
    logic [15:0] out_result;

    int    n_checks = 0;
    int    n_fail   = 0;
    logic        ring_v   [4];
    logic [15:0] ring_res [4];
    string       ring_tag [4];
    int          ptr = 0;

    always #5 clk = ~clk;

    fpa_pipe4 i_fpa_pipe4 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .op_a(op_a), .op_b(op_b), .op_sub(op_sub),
        .out_valid(out_valid), .out_result(out_result)
    );

    // Reference model written from the requirements.
    function automatic logic [15:0] model(logic [15:0] a, logic [15:0] b, logic sub);
        logic sa, sb, sbig, ssm;
        int ea, eb, ebig, esm, mbig, msm, al, sum, e;
        sa = a[15]; sb = b[15] ^ sub;
        ea = int'(a[14:9]); eb = int'(b[14:9]);
        if (a[14:0] >= b[14:0]) begin
            sbig = sa; ssm = sb; ebig = ea; esm = eb;
            mbig = (ea != 0 ? 512 : 0) + int'(a[8:0]);
            msm  = (eb != 0 ? 512 : 0) + int'(b[8:0]);
        end else begin
            sbig = sb; ssm = sa; ebig = eb; esm = ea;
            mbig = (eb != 0 ? 512 : 0) + int'(b[8:0]);
            msm  = (ea != 0 ? 512 : 0) + int'(a[8:0]);
        end
        al  = (ebig - esm > 10) ? 0 : (msm >> (ebig - esm));
        sum = (sbig != ssm) ? mbig - al : mbig + al;
        if (sum == 0) return 16'h0000;
        e = ebig;
        if (sum >= 1024) begin
            sum = sum >> 1; e = e + 1;
        end else begin
            while (sum < 512) begin sum = sum << 1; e = e - 1; end
            if (e < 1) return 16'h0000;
        end
        return {sbig, 6'(e), 9'(sum)};
    endfunction

    // Check the slot due now, then drive a new pair and record its expectation.
    task automatic step(input logic v, input logic [15:0] a, input logic [15:0] b,
                        input logic s, input string tag);
        @(negedge clk);
        n_checks++;
        if (out_valid !== ring_v[ptr]) begin
            n_fail++;
            $display("FAIL R1 %s: out_valid=%b expected=%b", ring_tag[ptr], out_valid, ring_v[ptr]);
        end else if (ring_v[ptr] && out_result !== ring_res[ptr]) begin
            n_fail++;
            $display("FAIL %s: result=%h expected=%h", ring_tag[ptr], out_result, ring_res[ptr]);
        end
        in_valid = v; op_a = a; op_b = b; op_sub = s;
        ring_v[ptr]   = v;
        ring_res[ptr] = model(a, b, s);
        ring_tag[ptr] = tag;
        ptr = (ptr + 1) % 4;
    endtask

    function automatic logic [15:0] rnd_op();
        logic [15:0] x;
        x = 16'($urandom());
        x[14:9] = 6'(1 + ($urandom() % 61));
        return x;
    endfunction

    // Watchdog: an overrun counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R1 watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 4; i++) begin
            ring_v[i] = 1'b0; ring_res[i] = '0; ring_tag[i] = "R1 bubble";
        end
        in_valid = 1'b1; op_a = 16'h3E00; op_b = 16'h3E00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_checks++;
        if (out_valid !== 1'b0 || out_result !== 16'h0000) begin
            n_fail++;
            $display("FAIL R10: valid=%b result=%h expected=0 0000", out_valid, out_result);
        end
        in_valid = 1'b0;
        rst_n = 1'b1;
        step(1, 16'h3E00, 16'h3E00, 0, "R6 1+1 carry");
        step(1, 16'h3F00, 16'h3F00, 1, "R8 x-x zero");
        step(1, 16'h3E00, 16'h3D00, 1, "R7 1-0.75 cancel");
        step(0, 16'h1234, 16'h4321, 0, "R1 bubble");
        step(1, 16'h6400, 16'h3E55, 0, "R5 far gap");
        step(1, 16'h6400, 16'h3E55, 1, "R5 far gap sub");
        step(1, 16'h3E00, 16'hBE00, 1, "R3 a-(-b)");
        step(1, 16'h3E00, 16'h4000, 1, "R9 small-big negative");
        step(1, 16'hBE80, 16'h3E00, 0, "R9 neg larger");
        step(1, 16'h03FF, 16'h03FE, 1, "R8 underflow flush");
        step(1, 16'h0000, 16'h4321, 0, "R2 zero operand");
        step(1, 16'h4321, 16'h0000, 1, "R2 minus zero");
        step(1, 16'h3E00, 16'h381F, 0, "R4 gap 3 truncation");
        step(1, 16'h3E0F, 16'h3C07, 1, "R4 gap 1 sub truncation");
        step(1, 16'h7A01, 16'h7A01, 0, "R6 high exponent carry");
        for (int k = 0; k < 400; k++) begin
            step(($urandom() % 5) != 0, rnd_op(), rnd_op(), 1'($urandom()), "R4 random");
        end
        for (int k = 0; k < 40; k++) begin
            logic [15:0] x;
            x = rnd_op();
            step(1, x, {x[15:9], 9'($urandom())}, 1'($urandom()), "R7 random near-cancel");
        end
        for (int k = 0; k < 4; k++) step(0, 16'h0, 16'h0, 0, "R1 drain");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule